// File: doc/BRIEF.md
# Sensor Sync and Capture Window

This block sits at the front of a raw image sensor port and runs in the pixel clock domain. Each cycle it samples one word from the sensor bus, together with a horizontal sync, a vertical sync, a field line and an external write-enable. The two syncs share one direction control. The block either takes them from the sensor or makes them itself from a programmed line period, line count and pulse widths. The field line has its own direction control. When the block drives the field line, the field flips once per generated frame.

Each sync line, the field line and the data bus can be inverted on its own. The sampled word is shifted right so that a sample of 8 to 16 bits ends up in the least significant bits. Column and row counters follow the active edges of the syncs. A pixel is marked valid from a rectangular capture window, optionally combined with the write-enable input. The outputs are a valid strobe, the aligned data, the pixel position and the field identifier. All of them are registered, two clock edges after the pins were sampled.

Top module: `sensor_capture_front`

## Requirements
- R1: While `rst_n` is low, `pix_valid`, `pix_col`, `pix_row` and `field_id` are 0. `hd_oe`/`vd_oe` equal `cfg_sync_drive` and `fld_oe` equals `cfg_fld_drive`.
- R2: With `cfg_sync_drive`=1 the block drives HD and VD (`hd_oe`=`vd_oe`=1), and `hd_in`/`vd_in` are ignored. The active HD level lasts `cfg_hd_width` cycles out of every `cfg_ppl` cycles. The active VD level lasts `cfg_vd_width` lines out of every `cfg_lpf` lines. Both start at their active level right after reset.
- R3: Polarity is set separately by `cfg_hs_inv`, `cfg_vs_inv`, `cfg_fld_inv` and `cfg_dat_inv` (1 = invert). Each pin level equals the internal active level XOR its invert bit, in both directions. The data bus is complemented before alignment.
- R4: `pix_data` is the sampled bus shifted right by 16 − b (for the default 16-bit bus). Here b is `cfg_bits` limited to the range 8..16: a value below 8 acts as 8, and a value above 16 acts as 16.
- R5: The pixel sampled in the first cycle where the active HD level is seen after an inactive cycle gets `pix_col` 0. Every later pixel gets the previous column plus one, modulo 2^CW.
- R6: The pixel sampled with the first active VD cycle gets `pix_row` 0. Otherwise `pix_row` goes up by one at each HD active edge and holds between edges.
- R7: A pixel is in the window when `cfg_win_sph` ≤ col < `cfg_win_sph`+`cfg_win_nph` and `cfg_win_slv` ≤ row < `cfg_win_slv`+`cfg_win_nlv`.
- R8: With `cfg_we_use`=0, `pix_valid` is the window condition alone. With `cfg_we_use`=1 and `cfg_we_or`=0, it is write-enable AND window. With `cfg_we_use`=1 and `cfg_we_or`=1, it is write-enable OR window.
- R9: When the field line is an input and `cfg_fld_latch`=1, `field_id` takes the field sampled with the VD active edge and holds it until the next such edge. With `cfg_fld_latch`=0 it follows the sampled field pixel by pixel.
- R10: With `cfg_fld_drive`=1 the block drives the field line (`fld_oe`=1). The internal field starts at 0 and flips at the start of each generated frame, and `field_id` follows it.
- R11: `pix_data`, `pix_valid` and the position outputs describe the pins sampled two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sync_drive | input | 1 | 1: block drives HD/VD; 0: samples them |
| cfg_fld_drive | input | 1 | 1: block drives the field line |
| cfg_fld_latch | input | 1 | 1: input field held from VD edge to VD edge |
| cfg_hs_inv | input | 1 | Invert HD pin |
| cfg_vs_inv | input | 1 | Invert VD pin |
| cfg_fld_inv | input | 1 | Invert field pin |
| cfg_dat_inv | input | 1 | Invert data bus |
| cfg_bits | input | BW (5) | Sample width in bits, limited to 8..DW |
| cfg_ppl | input | CW | Generated line period in cycles |
| cfg_hd_width | input | CW | Generated HD active cycles |
| cfg_lpf | input | CW | Generated lines per frame |
| cfg_vd_width | input | CW | Generated VD active lines |
| cfg_win_sph | input | CW | Window first column |
| cfg_win_nph | input | CW | Window column count |
| cfg_win_slv | input | CW | Window first row |
| cfg_win_nlv | input | CW | Window row count |
| cfg_we_use | input | 1 | Use the external write-enable |
| cfg_we_or | input | 1 | 1: OR with window; 0: AND |
| pix_in | input | DW | Sensor data bus |
| we_in | input | 1 | External write-enable |
| hd_in | input | 1 | HD pin input |
| vd_in | input | 1 | VD pin input |
| fld_in | input | 1 | Field pin input |
| hd_out | output | 1 | HD pin output level |
| hd_oe | output | 1 | HD output enable |
| vd_out | output | 1 | VD pin output level |
| vd_oe | output | 1 | VD output enable |
| fld_out | output | 1 | Field pin output level |
| fld_oe | output | 1 | Field output enable |
| pix_valid | output | 1 | Qualified pixel strobe |
| pix_data | output | DW | Right-aligned pixel data |
| pix_col | output | CW | Pixel column |
| pix_row | output | CW | Pixel row |
| field_id | output | 1 | Current field |

## Verification
The window and qualification logic is tried with syncs taken from the sensor and with syncs made by the block. Matching columns and rows in both cases show that the counters follow the active edges whatever their source. Inverted sync, field and data polarities are run against plain ones, so that a missing or misplaced XOR shows up as shifted rows or complemented samples. Write-enable is tried off, in AND mode and in OR mode with random enables, which separates the three validity rules. Field input is tried live and latched, with a field change placed mid-frame, so that the two field modes give different results. Sample widths of 12, 10, a too-small 4 and a too-large 20 check the shift and its limits.

// File: rtl/scw_pkg.sv
package scw_pkg;

  localparam int unsigned SCW_MIN_BITS = 8;

  // right shift that moves a sample of 'bits' width down to bit 0
  function automatic int unsigned align_shift(input int unsigned bits,
                                              input int unsigned full);
    int unsigned eff;
    eff = bits;
    if (eff < SCW_MIN_BITS) eff = SCW_MIN_BITS;
    if (eff > full) eff = full;
    return full - eff;
  endfunction

  // position inside [start, start+len)
  function automatic logic in_span(input int unsigned pos,
                                   input int unsigned start,
                                   input int unsigned len);
    return (pos >= start) && (pos < start + len);
  endfunction

  // pixel validity from window and write-enable
  function automatic logic qualify(input logic use_we, input logic or_mode,
                                   input logic we, input logic win);
    if (!use_we) return win;
    return or_mode ? (we | win) : (we & win);
  endfunction

endpackage

// File: rtl/scw_sync_gen.sv
module scw_sync_gen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ppl,
  input  logic [CW-1:0] hdw,
  input  logic [CW-1:0] lpf,
  input  logic [CW-1:0] vdw,
  output logic          hd_lvl,
  output logic          vd_lvl,
  output logic          fld_lvl,
  output logic          frame_wrap
);
  logic [CW-1:0] h_q, v_q;
  logic          fld_q;
  logic          line_end;

  assign line_end   = (32'(h_q) + 1) >= 32'(ppl);
  assign frame_wrap = line_end && ((32'(v_q) + 1) >= 32'(lpf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      v_q   <= '0;
      fld_q <= 1'b0;
    end else begin
      if (line_end) begin
        h_q <= '0;
        v_q <= frame_wrap ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
      if (frame_wrap) fld_q <= ~fld_q;
    end
  end

  assign hd_lvl  = h_q < hdw;
  assign vd_lvl  = v_q < vdw;
  assign fld_lvl = fld_q;
endmodule

// File: rtl/scw_pos_track.sv
module scw_pos_track #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd_s1,
  input  logic          vd_s1,
  output logic          h_edge,
  output logic          v_edge,
  output logic [CW-1:0] col,
  output logic [CW-1:0] row
);
  logic hd_d, vd_d;

  assign h_edge = hd_s1 & ~hd_d;
  assign v_edge = vd_s1 & ~vd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_d <= 1'b0;
      vd_d <= 1'b0;
      col  <= '0;
      row  <= '0;
    end else begin
      hd_d <= hd_s1;
      vd_d <= vd_s1;
      col  <= h_edge ? '0 : col + 1'b1;
      if (v_edge)      row <= '0;
      else if (h_edge) row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/scw_field_sel.sv
module scw_field_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_mode,
  input  logic v_edge,
  input  logic fld_s1,
  output logic field_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    field_q <= 1'b0;
    else if (!latch_mode || v_edge) field_q <= fld_s1;
  end
endmodule

// File: rtl/sensor_capture_front.sv
module sensor_capture_front #(
  parameter  int DW = 16,
  parameter  int CW = 12,
  localparam int BW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sync_drive,
  input  logic          cfg_fld_drive,
  input  logic          cfg_fld_latch,
  input  logic          cfg_hs_inv,
  input  logic          cfg_vs_inv,
  input  logic          cfg_fld_inv,
  input  logic          cfg_dat_inv,
  input  logic [BW-1:0] cfg_bits,
  input  logic [CW-1:0] cfg_ppl,
  input  logic [CW-1:0] cfg_hd_width,
  input  logic [CW-1:0] cfg_lpf,
  input  logic [CW-1:0] cfg_vd_width,
  input  logic [CW-1:0] cfg_win_sph,
  input  logic [CW-1:0] cfg_win_nph,
  input  logic [CW-1:0] cfg_win_slv,
  input  logic [CW-1:0] cfg_win_nlv,
  input  logic          cfg_we_use,
  input  logic          cfg_we_or,
  input  logic [DW-1:0] pix_in,
  input  logic          we_in,
  input  logic          hd_in,
  input  logic          vd_in,
  input  logic          fld_in,
  output logic          hd_out,
  output logic          hd_oe,
  output logic          vd_out,
  output logic          vd_oe,
  output logic          fld_out,
  output logic          fld_oe,
  output logic          pix_valid,
  output logic [DW-1:0] pix_data,
  output logic [CW-1:0] pix_col,
  output logic [CW-1:0] pix_row,
  output logic          field_id
);
  import scw_pkg::*;

  // generator levels and internal events (visible to the checker)
  logic hd_gen, vd_gen, fld_gen, gen_frame_wrap;
  logic h_edge, v_edge;
  logic hd_act, vd_act, fld_act;

  scw_sync_gen #(.CW(CW)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .ppl(cfg_ppl), .hdw(cfg_hd_width), .lpf(cfg_lpf), .vdw(cfg_vd_width),
    .hd_lvl(hd_gen), .vd_lvl(vd_gen), .fld_lvl(fld_gen),
    .frame_wrap(gen_frame_wrap)
  );

  assign hd_out  = hd_gen ^ cfg_hs_inv;
  assign vd_out  = vd_gen ^ cfg_vs_inv;
  assign fld_out = fld_gen ^ cfg_fld_inv;
  assign hd_oe   = cfg_sync_drive;
  assign vd_oe   = cfg_sync_drive;
  assign fld_oe  = cfg_fld_drive;

  assign hd_act  = cfg_sync_drive ? hd_gen  : (hd_in  ^ cfg_hs_inv);
  assign vd_act  = cfg_sync_drive ? vd_gen  : (vd_in  ^ cfg_vs_inv);
  assign fld_act = cfg_fld_drive  ? fld_gen : (fld_in ^ cfg_fld_inv);

  // stage 1: pin sampling
  logic [DW-1:0] pix_s1;
  logic          we_s1, hd_s1, vd_s1, fld_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_s1 <= '0;
      we_s1  <= 1'b0;
      hd_s1  <= 1'b0;
      vd_s1  <= 1'b0;
      fld_s1 <= 1'b0;
    end else begin
      pix_s1 <= pix_in ^ {DW{cfg_dat_inv}};
      we_s1  <= we_in;
      hd_s1  <= hd_act;
      vd_s1  <= vd_act;
      fld_s1 <= fld_act;
    end
  end

  // stage 2: position, field and qualification
  logic [CW-1:0] col_nx, row_nx;

  scw_pos_track #(.CW(CW)) u_pos (
    .clk(clk), .rst_n(rst_n), .hd_s1(hd_s1), .vd_s1(vd_s1),
    .h_edge(h_edge), .v_edge(v_edge), .col(pix_col), .row(pix_row)
  );

  scw_field_sel u_fld (
    .clk(clk), .rst_n(rst_n),
    .latch_mode(cfg_fld_latch & ~cfg_fld_drive),
    .v_edge(v_edge), .fld_s1(fld_s1), .field_q(field_id)
  );

  // column and row the pixel in stage 1 is about to receive
  assign col_nx = h_edge ? '0 : pix_col + 1'b1;
  always_comb begin
    if (v_edge)      row_nx = '0;
    else if (h_edge) row_nx = pix_row + 1'b1;
    else             row_nx = pix_row;
  end

  logic in_win;
  assign in_win = in_span(32'(col_nx), 32'(cfg_win_sph), 32'(cfg_win_nph)) &&
                  in_span(32'(row_nx), 32'(cfg_win_slv), 32'(cfg_win_nlv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      pix_valid <= qualify(cfg_we_use, cfg_we_or, we_s1, in_win);
      pix_data  <= pix_s1 >> align_shift(32'(cfg_bits), DW);
    end
  end
endmodule

// File: rtl/scw_checker.sv
module scw_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_sync_drive,
  input logic          cfg_fld_drive,
  input logic          cfg_hs_inv,
  input logic [CW-1:0] cfg_ppl,
  input logic [CW-1:0] cfg_hd_width,
  input logic [CW-1:0] cfg_win_sph,
  input logic [CW-1:0] cfg_win_nph,
  input logic [CW-1:0] cfg_win_slv,
  input logic [CW-1:0] cfg_win_nlv,
  input logic          cfg_we_use,
  input logic          cfg_we_or,
  input logic          we_in,
  input logic          hd_out,
  input logic          fld_out,
  input logic          h_edge,
  input logic          v_edge,
  input logic          gen_frame_wrap,
  input logic          pix_valid,
  input logic [CW-1:0] pix_col,
  input logic [CW-1:0] pix_row
);
  import scw_pkg::*;

  logic [CW:0] hd_run;
  logic        hd_hi;
  assign hd_hi = cfg_sync_drive && (hd_out ^ cfg_hs_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hd_run <= '0;
    else if (!hd_hi)     hd_run <= '0;
    else if (hd_run != '1) hd_run <= hd_run + 1'b1;
  end

  p_col_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    h_edge |=> pix_col == '0);

  p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !h_edge |=> (pix_col - $past(pix_col)) == CW'(1));

  p_row_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> pix_row == '0);

  p_valid_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we_use && pix_valid) |->
      (in_span(32'(pix_col), 32'(cfg_win_sph), 32'(cfg_win_nph)) &&
       in_span(32'(pix_row), 32'(cfg_win_slv), 32'(cfg_win_nlv))));

  p_and_needs_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_use && !cfg_we_or && pix_valid) |-> $past(we_in, 2));

  p_hd_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_hi && (cfg_hd_width < cfg_ppl)) |-> ({1'b0, cfg_hd_width} > hd_run));

  p_field_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fld_drive && gen_frame_wrap) |=> fld_out != $past(fld_out));
endmodule

bind sensor_capture_front scw_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_sync_drive(cfg_sync_drive), .cfg_fld_drive(cfg_fld_drive),
  .cfg_hs_inv(cfg_hs_inv), .cfg_ppl(cfg_ppl), .cfg_hd_width(cfg_hd_width),
  .cfg_win_sph(cfg_win_sph), .cfg_win_nph(cfg_win_nph),
  .cfg_win_slv(cfg_win_slv), .cfg_win_nlv(cfg_win_nlv),
  .cfg_we_use(cfg_we_use), .cfg_we_or(cfg_we_or), .we_in(we_in),
  .hd_out(hd_out), .fld_out(fld_out), .h_edge(h_edge), .v_edge(v_edge),
  .gen_frame_wrap(gen_frame_wrap), .pix_valid(pix_valid),
  .pix_col(pix_col), .pix_row(pix_row)
);

// File: tb/sensor_capture_front_test.sv
module sensor_capture_front_test;
  localparam int DW = 16;
  localparam int CW = 12;
  localparam int BW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_sync_drive = 0, cfg_fld_drive = 0, cfg_fld_latch = 0;
  logic cfg_hs_inv = 0, cfg_vs_inv = 0, cfg_fld_inv = 0, cfg_dat_inv = 0;
  logic [BW-1:0] cfg_bits = '0;
  logic [CW-1:0] cfg_ppl = '0, cfg_hd_width = '0, cfg_lpf = '0, cfg_vd_width = '0;
  logic [CW-1:0] cfg_win_sph = '0, cfg_win_nph = '0, cfg_win_slv = '0, cfg_win_nlv = '0;
  logic cfg_we_use = 0, cfg_we_or = 0;
  logic [DW-1:0] pix_in = '0;
  logic we_in = 0, hd_in = 0, vd_in = 0, fld_in = 0;
  logic hd_out, hd_oe, vd_out, vd_oe, fld_out, fld_oe;
  logic pix_valid, field_id;
  logic [DW-1:0] pix_data;
  logic [CW-1:0] pix_col, pix_row;

  sensor_capture_front #(.DW(DW), .CW(CW)) uut (.*);

  int total = 0, bad = 0;

  // sensor-side sync pattern (bench own counters)
  int s_len, s_hw, s_lines, s_vw, s_h, s_v, s_fld;
  // reference model state
  int m_gh, m_gv, m_fg;
  int m_p1, m_we1, m_hd1, m_vd1, m_f1, m_hdd, m_vdd;
  int m_col, m_row, m_fid, m_val, m_dat;
  int force_val;
  bit force_on;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_bits(input int b);
    if (b < 8) return 8;
    if (b > 16) return 16;
    return b;
  endfunction

  task automatic model_edge();
    int he, ve, win;
    if (!rst_n) begin
      m_gh = 0; m_gv = 0; m_fg = 0;
      m_p1 = 0; m_we1 = 0; m_hd1 = 0; m_vd1 = 0; m_f1 = 0; m_hdd = 0; m_vdd = 0;
      m_col = 0; m_row = 0; m_fid = 0; m_val = 0; m_dat = 0;
      return;
    end
    he = (m_hd1 == 1 && m_hdd == 0) ? 1 : 0;
    ve = (m_vd1 == 1 && m_vdd == 0) ? 1 : 0;
    m_col = he ? 0 : (m_col + 1) % 4096;
    if (ve) m_row = 0;
    else if (he) m_row = (m_row + 1) % 4096;
    win = (m_col >= int'(cfg_win_sph) && m_col < int'(cfg_win_sph) + int'(cfg_win_nph) &&
           m_row >= int'(cfg_win_slv) && m_row < int'(cfg_win_slv) + int'(cfg_win_nlv)) ? 1 : 0;
    if (!cfg_we_use) m_val = win;
    else if (cfg_we_or) m_val = m_we1 | win;
    else m_val = m_we1 & win;
    m_dat = m_p1 / (1 << (16 - eff_bits(int'(cfg_bits))));
    if (cfg_fld_latch && !cfg_fld_drive) begin
      if (ve) m_fid = m_f1;
    end else m_fid = m_f1;
    m_hdd = m_hd1;
    m_vdd = m_vd1;
    // sample the pins
    m_hd1 = cfg_sync_drive ? (m_gh < int'(cfg_hd_width)) : int'(hd_in ^ cfg_hs_inv);
    m_vd1 = cfg_sync_drive ? (m_gv < int'(cfg_vd_width)) : int'(vd_in ^ cfg_vs_inv);
    m_f1  = cfg_fld_drive ? m_fg : int'(fld_in ^ cfg_fld_inv);
    m_p1  = cfg_dat_inv ? (32'(pix_in) ^ 32'hFFFF) : 32'(pix_in);
    m_we1 = int'(we_in);
    // generator advance
    if (m_gh + 1 >= int'(cfg_ppl)) begin
      m_gh = 0;
      if (m_gv + 1 >= int'(cfg_lpf)) begin m_gv = 0; m_fg ^= 1; end
      else m_gv++;
    end else m_gh++;
  endtask

  task automatic compare();
    chk("R8 valid", 32'(pix_valid), m_val);
    chk("R4 data", 32'(pix_data), m_dat);
    chk("R5 column", 32'(pix_col), m_col);
    chk("R6 row", 32'(pix_row), m_row);
    chk(cfg_fld_drive ? "R10 field" : "R9 field", 32'(field_id), m_fid);
    chk("R2 hd_oe", 32'(hd_oe), 32'(cfg_sync_drive));
    chk("R2 vd_oe", 32'(vd_oe), 32'(cfg_sync_drive));
    chk("R10 fld_oe", 32'(fld_oe), 32'(cfg_fld_drive));
    if (cfg_sync_drive) begin
      chk("R3 hd_out", 32'(hd_out), (m_gh < int'(cfg_hd_width)) ^ int'(cfg_hs_inv));
      chk("R3 vd_out", 32'(vd_out), (m_gv < int'(cfg_vd_width)) ^ int'(cfg_vs_inv));
    end
    if (cfg_fld_drive) chk("R10 fld_out", 32'(fld_out), m_fg ^ int'(cfg_fld_inv));
  endtask

  task automatic drive_pins();
    pix_in = force_on ? 16'(force_val) : 16'($urandom);
    force_on = 0;
    we_in = 1'($urandom);
    if (cfg_sync_drive) begin
      hd_in = 1'($urandom);
      vd_in = 1'($urandom);
    end else begin
      hd_in = (s_h < s_hw) ^ cfg_hs_inv;
      vd_in = (s_v < s_vw) ^ cfg_vs_inv;
    end
    if (s_h == 5 && s_v == 2) s_fld ^= 1;
    fld_in = 1'(s_fld) ^ cfg_fld_inv;
    if (s_h + 1 >= s_len) begin
      s_h = 0;
      s_v = (s_v + 1 >= s_lines) ? 0 : s_v + 1;
    end else s_h++;
  endtask

  task automatic cycle();
    @(negedge clk);
    compare();
    drive_pins();
    model_edge();
  endtask

  task automatic start_scn(input int len, input int hw, input int lines, input int vw);
    @(negedge clk);
    rst_n = 1'b0;
    s_len = len; s_hw = hw; s_lines = lines; s_vw = vw; s_h = 0; s_v = 0; s_fld = 0;
    model_edge();
    repeat (2) begin
      @(negedge clk);
      chk("R1 reset valid", 32'(pix_valid), 0);
      chk("R1 reset col", 32'(pix_col), 0);
      chk("R1 reset row", 32'(pix_row), 0);
      chk("R1 reset field", 32'(field_id), 0);
      chk("R1 reset oe", 32'(hd_oe), 32'(cfg_sync_drive));
    end
    rst_n = 1'b1;
    drive_pins();
    model_edge();
  endtask

  task automatic forced_word(input int word, input int exp, input string req);
    force_val = word;
    force_on = 1;
    cycle();
    cycle();
    cycle();
    chk(req, 32'(pix_data), exp);
  endtask

  task automatic set_win(input int sph, input int nph, input int slv, input int nlv);
    cfg_win_sph = CW'(sph); cfg_win_nph = CW'(nph);
    cfg_win_slv = CW'(slv); cfg_win_nlv = CW'(nlv);
  endtask

  initial begin
    // A: syncs from sensor, plain polarity, window only, 12-bit samples
    set_win(3, 6, 1, 3);
    cfg_bits = 5'd12; cfg_ppl = 12'd10; cfg_hd_width = 12'd3; cfg_lpf = 12'd5; cfg_vd_width = 12'd2;
    start_scn(16, 2, 6, 1);
    repeat (40) cycle();
    forced_word(16'hABCD, 16'h0ABC, "R11 R4 latency 12-bit");
    repeat (250) cycle();

    // B: inverted polarities, AND with write-enable, latched field, 10-bit
    cfg_hs_inv = 1; cfg_vs_inv = 1; cfg_dat_inv = 1; cfg_fld_inv = 1;
    cfg_we_use = 1; cfg_we_or = 0; cfg_fld_latch = 1; cfg_bits = 5'd10;
    set_win(2, 8, 0, 4);
    start_scn(14, 3, 5, 2);
    repeat (30) cycle();
    forced_word(16'h0000, 16'h03FF, "R3 R4 inverted 10-bit");
    repeat (300) cycle();

    // C: OR with write-enable, live field, width below range
    cfg_hs_inv = 0; cfg_vs_inv = 0; cfg_dat_inv = 0; cfg_fld_inv = 0;
    cfg_we_or = 1; cfg_fld_latch = 0; cfg_bits = 5'd4;
    set_win(4, 3, 2, 2);
    start_scn(12, 1, 7, 2);
    forced_word(16'hABCD, 16'h00AB, "R4 width below 8");
    repeat (300) cycle();

    // D: block drives syncs and field, width above range
    cfg_sync_drive = 1; cfg_fld_drive = 1; cfg_hs_inv = 1; cfg_fld_inv = 1;
    cfg_we_use = 0; cfg_we_or = 0; cfg_bits = 5'd20;
    cfg_ppl = 12'd12; cfg_hd_width = 12'd3; cfg_lpf = 12'd5; cfg_vd_width = 12'd2;
    set_win(2, 4, 0, 2);
    start_scn(9, 2, 4, 1);
    forced_word(16'hABCD, 16'hABCD, "R4 width above 16");
    repeat (300) cycle();

    // E: generated syncs, field input latched by generated VD
    cfg_fld_drive = 0; cfg_fld_latch = 1; cfg_hs_inv = 0; cfg_vs_inv = 1; cfg_fld_inv = 0;
    cfg_ppl = 12'd7; cfg_hd_width = 12'd1; cfg_lpf = 12'd6; cfg_vd_width = 12'd1;
    cfg_bits = 5'd16;
    set_win(1, 5, 1, 4);
    start_scn(5, 1, 3, 1);
    repeat (300) cycle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule